// File: doc/BRIEF.md
# Dual-Register Timer Input Capture

A free-running up-counter with two capture registers, A and B, each loaded with the counter value when a qualified edge arrives on an external trigger pin. `pin_i[0]` is register A's own pin and `pin_i[1]` is register B's pin. A select input decides whether register A listens to its own pin or to the opposite one. Each pin passes through a synchronizer and a width filter. A per-pin edge-select field picks which transitions count. Every capture raises a one-cycle interrupt pulse.

The counter advances on a count-clock enable (`tick_i`) while `run_i` is high. A qualified edge is held pending and taken on the next tick. That tick latches the counter value that was in effect during the period. The interrupt follows one clock later. Either register can instead act as a compare register, written by software, which interrupts when the running counter reaches it. Software reads one register at a time. When a read or a timer stop lands in the same cycle as a capture, the capture still goes ahead and the register's sticky invalid flag is set.

Top module: `dual_capture_timer`

## Requirements
- R1: `count_o` increments by one, wrapping from all ones to zero, in every clock where `run_i` and `tick_i` are both high, and otherwise holds. `clr_i` zeroes it.
- R2: A pin level change passes a two-flop synchronizer. It is accepted only once the synchronized level has differed from the accepted level for `QUAL_PERIODS` ticks. A change that reverts sooner is ignored.
- R3: The per-pin edge select is 00 none, 01 rising, 10 falling, 11 both. A selected edge of the accepted level is held pending. At the next tick the register loads the `count_o` value present in that clock.
- R4: `irq_o[0]` (A) and `irq_o[1]` (B) pulse high for one clock, in the clock after a capture, compare match or interrupt-only event. They are never high unless `tick_i` was high in the preceding clock.
- R5: Register B always captures on pin 1 edges. With `src_own_i` = 0, register A captures on pin 1 edges. With `src_own_i` = 1, register A captures on pin 0 edges.
- R6: With `src_own_i` = 1 and pin 0 edge select 11, register A never captures and pin 0 raises no interrupt.
- R7: With `src_own_i` = 1, a selected pin 1 edge raises `irq_o[0]` at the next tick without loading register A.
- R8: A register with its `cmp_mode_i` bit set ignores triggers. `wr_i` loads it (`wr_sel_i` 0 = A, 1 = B), though a capture in the same clock wins. It interrupts when `run_i`, `tick_i` and `count_o` equal to its value coincide.
- R9: When `rd_i` is high, the next clock shows the selected register (`rd_sel_i` 0 = A, 1 = B) on `rd_data_o` and its invalid state on `rd_inv_o`. Both hold otherwise.
- R10: A capture into the register being read in that same clock still loads. `rd_inv_o` reads 1 and the sticky flag is set.
- R11: A capture in a clock where `run_i` is low but was high in the previous clock sets that register's sticky flag.
- R12: A read without a conflict clears the register's sticky flag after reporting it. `clr_i` zeroes the counter, both registers, flags, pending events, interrupts and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear |
| run_i | input | 1 | Counter run enable |
| tick_i | input | 1 | Count-clock enable pulse |
| pin_i | input | 2 | Trigger pins, bit 0 own pin of A, bit 1 of B |
| edge0_i | input | 2 | Edge select for pin 0 |
| edge1_i | input | 2 | Edge select for pin 1 |
| src_own_i | input | 1 | 1: A triggered by pin 0, 0: by pin 1 |
| cmp_mode_i | input | 2 | Per-register compare mode, bit 0 A, bit 1 B |
| wr_i | input | 1 | Compare value write strobe |
| wr_sel_i | input | 1 | Write target register |
| wr_data_i | input | CNT_W | Compare value |
| rd_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | Read target register |
| count_o | output | CNT_W | Counter value |
| irq_o | output | 2 | Interrupt pulses, bit 0 A, bit 1 B |
| rd_data_o | output | CNT_W | Read data |
| rd_inv_o | output | 1 | Read data not guaranteed |

## Verification
The bench builds the block with an 8-bit counter and `QUAL_PERIODS` = 3. The narrow counter wraps every 256 ticks, so wrap-around captures and compare matches against written values occur many times per phase. Three ticks of qualification let random pin pulses of one to eight clocks fall on both sides of the width filter. The bench runs the tick both every clock and at a sparse rate, and it times reads and stops from its own model so that read and stop collisions with captures are hit on purpose.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/dct_input_qual.sv
`timescale 1ns/1ps
module dct_input_qual #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_PERIODS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       ev_o
);
  localparam int QW = $clog2(QUAL_PERIODS) + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_s;
  logic                   filt_q, prev_q;
  logic [QW-1:0]          qcnt_q;
  logic                   rise, fall;

  assign lvl_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      qcnt_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= filt_q;
      if (lvl_s == filt_q) begin
        qcnt_q <= '0;
      end else if (tick_i) begin
        if (qcnt_q == QW'(QUAL_PERIODS - 1)) begin
          filt_q <= lvl_s;
          qcnt_q <= '0;
        end else begin
          qcnt_q <= qcnt_q + 1'b1;
        end
      end
    end
  end

  assign rise = filt_q & ~prev_q;
  assign fall = ~filt_q & prev_q;
  assign ev_o = (edge_sel_i[0] & rise) | (edge_sel_i[1] & fall);
endmodule

// File: rtl/dct_capture_reg.sv
`timescale 1ns/1ps
module dct_capture_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             stop_hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ld_ev_i,
  input  logic             irq_ev_i,
  input  logic             cmp_mode_i,
  input  logic             rd_hit_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] data_o,
  output logic             inv_o,
  output logic             conf_o,
  output logic             irq_o
);
  logic             pend_ld_q, pend_irq_q;
  logic [CNT_W-1:0] data_q;
  logic             inv_q, irq_q;
  logic             take_ld, take_irq, match;

  assign take_ld  = tick_i & pend_ld_q & ~cmp_mode_i;
  assign take_irq = tick_i & pend_irq_q & ~cmp_mode_i;
  assign match    = cmp_mode_i & tick_i & run_i & (cnt_i == data_q);
  assign conf_o   = take_ld & (rd_hit_i | stop_hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ld_q  <= 1'b0;
      pend_irq_q <= 1'b0;
      data_q     <= '0;
      inv_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else if (clr_i) begin
      pend_ld_q  <= 1'b0;
      pend_irq_q <= 1'b0;
      data_q     <= '0;
      inv_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      // compare mode drops trigger events outright
      pend_ld_q  <= ~cmp_mode_i & ((pend_ld_q & ~tick_i) | ld_ev_i);
      pend_irq_q <= ~cmp_mode_i & ((pend_irq_q & ~tick_i) | irq_ev_i);
      if (take_ld)      data_q <= cnt_i;
      else if (wr_en_i) data_q <= wr_data_i;
      if (conf_o)        inv_q <= 1'b1;
      else if (rd_hit_i) inv_q <= 1'b0;
      irq_q <= take_ld | take_irq | match;
    end
  end

  assign data_o = data_q;
  assign inv_o  = inv_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dual_capture_timer.sv
`timescale 1ns/1ps
module dual_capture_timer
  import dct_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int QUAL_PERIODS = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [1:0]       pin_i,
  input  logic [1:0]       edge0_i,
  input  logic [1:0]       edge1_i,
  input  logic             src_own_i,
  input  logic [1:0]       cmp_mode_i,
  input  logic             wr_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_i,
  input  logic             rd_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic [1:0]       irq_o,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_inv_o
);
  localparam int NREG = 2;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, stop_hit;
  logic [1:0][1:0]  edge_sel;
  logic [1:0]       pin_ev;
  logic [NREG-1:0]  ld_ev, irq_ev, rd_hit, wr_en, cap_inv, cap_conf, cap_irq;
  logic [CNT_W-1:0] cap_data [NREG];
  logic [CNT_W-1:0] rd_data_q;
  logic             rd_inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (clr_i)               cnt_q <= '0;
      else if (run_i & tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stop_hit = run_q & ~run_i;
  assign edge_sel = {edge1_i, edge0_i};

  for (genvar p = 0; p < 2; p++) begin : g_pin
    dct_input_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .QUAL_PERIODS(QUAL_PERIODS)
    ) i_qual (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .pin_i     (pin_i[p]),
      .edge_sel_i(edge_sel[p]),
      .ev_o      (pin_ev[p])
    );
  end

  // A: own pin excludes both-edge select; opposite pin only interrupts when own is selected
  assign ld_ev[0]  = src_own_i ? (pin_ev[0] & (edge0_i != EDGE_BOTH)) : pin_ev[1];
  assign irq_ev[0] = src_own_i & pin_ev[1];
  assign ld_ev[1]  = pin_ev[1];
  assign irq_ev[1] = 1'b0;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    assign rd_hit[k] = rd_i & (rd_sel_i == k[0]);
    assign wr_en[k]  = wr_i & (wr_sel_i == k[0]);
    dct_capture_reg #(.CNT_W(CNT_W)) i_cap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_i),
      .tick_i    (tick_i),
      .run_i     (run_i),
      .stop_hit_i(stop_hit),
      .cnt_i     (cnt_q),
      .ld_ev_i   (ld_ev[k]),
      .irq_ev_i  (irq_ev[k]),
      .cmp_mode_i(cmp_mode_i[k]),
      .rd_hit_i  (rd_hit[k]),
      .wr_en_i   (wr_en[k]),
      .wr_data_i (wr_data_i),
      .data_o    (cap_data[k]),
      .inv_o     (cap_inv[k]),
      .conf_o    (cap_conf[k]),
      .irq_o     (cap_irq[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      rd_inv_q  <= 1'b0;
    end else if (clr_i) begin
      rd_data_q <= '0;
      rd_inv_q  <= 1'b0;
    end else if (rd_i) begin
      rd_data_q <= cap_data[rd_sel_i];
      rd_inv_q  <= cap_inv[rd_sel_i] | cap_conf[rd_sel_i];
    end
  end

  assign count_o   = cnt_q;
  assign irq_o     = cap_irq;
  assign rd_data_o = rd_data_q;
  assign rd_inv_o  = rd_inv_q;
endmodule

// File: rtl/dct_checker.sv
`timescale 1ns/1ps
module dct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             run_i,
  input logic             tick_i,
  input logic             rd_i,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       irq_o,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             rd_inv_o
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !clr_i |=> count_o == CNT_W'($past(count_o) + 1'b1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && tick_i) && !clr_i |=> $stable(count_o)); // R1
  AST_IRQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(tick_i)); // R4
  AST_CLR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0 && irq_o == 2'b00 && !rd_inv_o && rd_data_o == '0); // R12
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !clr_i |=> $stable(rd_data_o) && $stable(rd_inv_o)); // R9
endmodule

bind dual_capture_timer dct_checker #(.CNT_W(CNT_W)) i_dct_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .run_i    (run_i),
  .tick_i   (tick_i),
  .rd_i     (rd_i),
  .count_o  (count_o),
  .irq_o    (irq_o),
  .rd_data_o(rd_data_o),
  .rd_inv_o (rd_inv_o)
);

// File: tb/test_dual_capture_timer.sv
`timescale 1ns/1ps
module test_dual_capture_timer;
  localparam int CW = 8;
  localparam int QP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0, run = 1'b1, tick = 1'b0;
  logic [1:0]    pin = 2'b00;
  logic [1:0]    esel0 = 2'b00, esel1 = 2'b00;
  logic          src_own = 1'b0;
  logic [1:0]    cmp = 2'b00;
  logic          wr = 1'b0, wsel = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic          rd = 1'b0, rsel = 1'b0;
  logic [CW-1:0] count;
  logic [1:0]    irq;
  logic [CW-1:0] rdd;
  logic          rdi;

  always #10 clk = ~clk;

  dual_capture_timer #(.CNT_W(CW), .QUAL_PERIODS(QP), .SYNC_STAGES(2)) i_dual_capture_timer (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .run_i(run), .tick_i(tick),
    .pin_i(pin), .edge0_i(esel0), .edge1_i(esel1), .src_own_i(src_own),
    .cmp_mode_i(cmp), .wr_i(wr), .wr_sel_i(wsel), .wr_data_i(wdata),
    .rd_i(rd), .rd_sel_i(rsel), .count_o(count), .irq_o(irq),
    .rd_data_o(rdd), .rd_inv_o(rdi)
  );

  // behavioural reference
  logic [CW-1:0] m_cnt, m_rdd;
  logic [CW-1:0] m_cap [2];
  bit   [1:0]    m_sy0, m_sy1, m_filt, m_prev, m_pl, m_pi, m_inv, m_irq;
  int            m_q [2];
  bit            m_rdi, m_runq;
  int            seen_rdconf = 0, seen_stopconf = 0, seen_irqonly = 0, seen_match = 0;

  bit [1:0] ev, ldv, iov, tl, ti, mt, rh, conf;
  bit       stop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_rdd = '0; m_rdi = 0; m_runq = 0;
      m_sy0 = 0; m_sy1 = 0; m_filt = 0; m_prev = 0; m_pl = 0; m_pi = 0; m_inv = 0; m_irq = 0;
      for (int k = 0; k < 2; k++) begin m_cap[k] = '0; m_q[k] = 0; end
    end else begin
      for (int p = 0; p < 2; p++) begin
        logic [1:0] es;
        es = (p == 0) ? esel0 : esel1;
        ev[p] = (es[0] && m_filt[p] && !m_prev[p]) || (es[1] && !m_filt[p] && m_prev[p]);
      end
      ldv[0] = src_own ? (ev[0] && esel0 != 2'b11) : ev[1];
      iov[0] = src_own && ev[1];
      ldv[1] = ev[1];
      iov[1] = 0;
      stop = m_runq && !run;
      for (int k = 0; k < 2; k++) begin
        tl[k] = tick && m_pl[k] && !cmp[k];
        ti[k] = tick && m_pi[k] && !cmp[k];
        mt[k] = cmp[k] && tick && run && (m_cap[k] == m_cnt);
        rh[k] = rd && (rsel == k[0]);
        conf[k] = tl[k] && (rh[k] || stop);
      end
      if (!clr) begin
        if (conf != 0 && rd && conf[rsel]) seen_rdconf++;
        if (stop && tl != 0) seen_stopconf++;
        if (ti[0]) seen_irqonly++;
        if (mt != 0) seen_match++;
      end
      if (clr) begin
        m_rdd = '0; m_rdi = 0;
      end else if (rd) begin
        m_rdd = m_cap[rsel];
        m_rdi = m_inv[rsel] || conf[rsel];
      end
      for (int k = 0; k < 2; k++) begin
        if (clr) begin
          m_cap[k] = '0; m_inv[k] = 0; m_irq[k] = 0; m_pl[k] = 0; m_pi[k] = 0;
        end else begin
          m_irq[k] = tl[k] || ti[k] || mt[k];
          if (tl[k]) m_cap[k] = m_cnt;
          else if (wr && wsel == k[0]) m_cap[k] = wdata;
          if (conf[k]) m_inv[k] = 1;
          else if (rh[k]) m_inv[k] = 0;
          m_pl[k] = !cmp[k] && ((m_pl[k] && !tick) || ldv[k]);
          m_pi[k] = !cmp[k] && ((m_pi[k] && !tick) || iov[k]);
        end
      end
      if (clr) m_cnt = '0;
      else if (run && tick) m_cnt = m_cnt + 1'b1;
      for (int p = 0; p < 2; p++) begin
        m_prev[p] = m_filt[p];
        if (m_sy1[p] == m_filt[p]) m_q[p] = 0;
        else if (tick) begin
          if (m_q[p] == QP - 1) begin m_filt[p] = m_sy1[p]; m_q[p] = 0; end
          else m_q[p] = m_q[p] + 1;
        end
        m_sy1[p] = m_sy0[p];
        m_sy0[p] = pin[p];
      end
      m_runq = run;
    end
  end

  int vecs = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(string req, string nm, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk($sformatf("R1/%s", tag), "count_o", int'(count), int'(m_cnt));
    chk($sformatf("R4/%s", tag), "irq_o", int'(irq), int'(m_irq));
    chk($sformatf("R9/%s", tag), "rd_data_o", int'(rdd), int'(m_rdd));
    chk($sformatf("R10/%s", tag), "rd_inv_o", int'(rdi), int'(m_rdi));
  endtask

  int  hold [2] = '{3, 5};
  bit  short_pulses = 0, sparse = 0, force_rd = 0, force_stop = 0, use_clr = 0, use_wr = 0;

  task automatic drive();
    tick = sparse ? ($urandom % 3 == 0) : 1'b1;
    for (int p = 0; p < 2; p++) begin
      if (hold[p] == 0) begin
        pin[p] = ~pin[p];
        hold[p] = short_pulses ? int'($urandom % 8) : int'($urandom % 20);
      end else hold[p]--;
    end
    rd = ($urandom % 8 == 0);
    rsel = $urandom % 2;
    if (force_rd && tick) begin
      for (int k = 0; k < 2; k++)
        if (m_pl[k] && !cmp[k]) begin rd = 1; rsel = k[0]; end
    end
    wr = use_wr && ($urandom % 48 == 0);
    wsel = 1'b0;
    wdata = CW'($urandom);
    clr = use_clr && ($urandom % 150 == 0);
    if (force_stop) begin
      if (run && tick && (m_pl != 0)) run = 0;
      else if (!run && $urandom % 4 == 0) run = 1;
    end else run = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();                                   // reset state
    rst_n = 1'b1;
    for (int ph = 0; ph < 9; ph++) begin
      short_pulses = 0; sparse = 0; force_rd = 0; force_stop = 0; use_clr = 0; use_wr = 0;
      cmp = 2'b00; src_own = 0; esel0 = 2'b01; esel1 = 2'b10;
      case (ph)
        0: tag = "R3";
        1: begin tag = "R2"; esel0 = 2'b11; esel1 = 2'b11; sparse = 1; short_pulses = 1; end
        2: begin tag = "R5"; src_own = 1; esel1 = 2'b11; end
        3: begin tag = "R6"; src_own = 1; esel0 = 2'b11; esel1 = 2'b00; end
        4: begin tag = "R7"; src_own = 1; esel0 = 2'b00; esel1 = 2'b01; end
        5: begin tag = "R8"; cmp = 2'b01; use_wr = 1; end
        6: begin tag = "R10"; force_rd = 1; esel1 = 2'b11; end
        7: begin tag = "R11"; force_stop = 1; sparse = 1; esel0 = 2'b11; esel1 = 2'b11; src_own = 1; end
        default: begin tag = "R12"; use_clr = 1; esel1 = 2'b11; end
      endcase
      repeat (1500) begin
        @(negedge clk);
        compare();
        drive();
      end
    end
    @(negedge clk);
    compare();
    chk("R10", "read collisions hit", int'(seen_rdconf > 0), 1);
    chk("R11", "stop collisions hit", int'(seen_stopconf > 0), 1);
    chk("R7", "interrupt-only events hit", int'(seen_irqonly > 0), 1);
    chk("R8", "compare matches hit", int'(seen_match > 0), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule